// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. A byte written into a one-entry holding buffer waits there until the frame shifter is free. It then moves into the shifter, which sends it one bit per tick of an external bit-rate strobe. While one character is on the line, the next can already sit in the buffer. The two busy indications are visible as separate flags. A one-clock interrupt pulse marks the end of every frame.

Configuration inputs set the frame shape: 7 or 8 data bits, one of four parity modes, and one or two stop bits. The shifter samples this shape when it loads a character. Transmission runs only while both a master clock enable and a transmit enable are high. Clearing either one aborts everything at once. After that the block needs a settling time of two bit ticks before it accepts data again. The line idles high.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, and `buf_full`, `shift_busy` and `tx_irq` are 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the optional parity bit, then high stop bits. `len8`=1 sends 8 data bits. `len8`=0 sends `wr_data[6:0]` and ignores bit 7.
- R3: `stop2`=1 sends two stop bits and `stop2`=0 sends one.
- R4: `par_mode` encodings are 00 no parity bit, 01 parity bit always 0, 10 odd, 11 even. Odd and even count the ones over the data bits plus the parity bit.
- R5: An accepted write sets `buf_full` in the next cycle. On the first `bit_tick` at which the shifter is idle or ending its last stop bit, the byte moves to the shifter. `buf_full` then clears, `shift_busy` is 1, and `txd` shows the start bit.
- R6: A write while `buf_full` is 1 is ignored. The waiting byte is neither replaced nor sent twice.
- R7: When a byte is waiting, its start bit follows the previous frame's last stop bit with no idle bit between them.
- R8: `tx_irq` is high for exactly one clock, right after the tick that ends each frame.
- R9: Transmission needs both `clk_en` and `tx_en`. While either is low, from the next cycle on, `txd` is 1, both flags are 0, and writes are ignored.
- R10: After the enables are cleared, writes are ignored until two `bit_tick` pulses have occurred since the cycle the enables dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per serial bit time |
| clk_en | input | 1 | Master clock enable |
| tx_en | input | 1 | Transmit enable |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_mode | input | 2 | Parity mode (see R4) |
| stop2 | input | 1 | 1: two stop bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output, idle high |
| buf_full | output | 1 | A byte waits in the holding buffer |
| shift_busy | output | 1 | A frame is being shifted out |
| tx_irq | output | 1 | One-clock pulse at the end of each frame |

## Verification
Two events can land on the same bit tick. One is the end of a frame's last stop bit, which raises the interrupt. The other is the hand-off of a waiting byte into the shifter. The bench provokes this by writing a second byte while the first is still shifting. It also tries a third write during the wait, which must be dropped. It then checks the recorded line: the second start bit must sit directly after the first stop bit. It also checks the flags at the right moments and counts exactly two interrupt pulses with no third frame.

// File: rtl/uart_tx_dbuf_pkg.sv
package uart_tx_dbuf_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = 12;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic      len8;
        par_mode_e par;
        logic      stop2;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    // Lay out one frame, LSB goes out first; unused upper bits stay high.
    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        frame_t     f;
        logic       ones;
        logic [3:0] ppos;
        f.bits      = '1;
        f.bits[0]   = 1'b0;
        f.bits[8:1] = c.len8 ? d : {1'b1, d[6:0]};
        ones        = c.len8 ? ^d : ^d[6:0];
        ppos        = c.len8 ? 4'd9 : 4'd8;
        case (c.par)
            PAR_ZERO: f.bits[ppos] = 1'b0;
            PAR_ODD:  f.bits[ppos] = ~ones;
            PAR_EVEN: f.bits[ppos] = ones;
            default:  ;
        endcase
        f.len = LEN_W'(ppos) + ((c.par == PAR_NONE) ? LEN_W'(0) : LEN_W'(1))
              + (c.stop2 ? LEN_W'(2) : LEN_W'(1));
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_dbuf_hold.sv
module uart_tx_dbuf_hold
    import uart_tx_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (run && full && wr_en && !take) |=> (full && $stable(data) || !$past(run))) // R6
        else $error("write while full changed the held byte");

endmodule

// File: rtl/uart_tx_dbuf_shift.sv
module uart_tx_dbuf_shift
    import uart_tx_dbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame,
    output logic   busy,
    output logic   last,
    output logic   txd
);

    logic [FRAME_MAX-1:0] sh;
    logic [LEN_W-1:0]     rem;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh  <= '1;
            rem <= '0;
        end else if (load) begin
            sh  <= frame.bits;
            rem <= frame.len;
        end else if (tick && rem != '0) begin
            sh  <= {1'b1, sh[FRAME_MAX-1:1]};
            rem <= rem - 1'b1;
        end
    end

    assign busy = (rem != '0);
    assign last = tick && (rem == LEN_W'(1));
    assign txd  = busy ? sh[0] : 1'b1;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (load && run) |=> (!txd || !$past(run))) // R2
        else $error("load not followed by start bit");

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_dbuf_pkg::*;
#(
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              clk_en,
    input  logic              tx_en,
    input  logic              len8,
    input  logic [1:0]        par_mode,
    input  logic              stop2,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              buf_full,
    output logic              shift_busy,
    output logic              tx_irq
);

    localparam int SW = $clog2(SETTLE_TICKS + 1);

    logic              en, en_q, settled, run;
    logic [SW-1:0]     settle_cnt;
    logic              take, frame_last;
    logic [DATA_W-1:0] held;
    frame_cfg_t        cfg;
    frame_t            frame;

    assign en      = clk_en && tx_en;
    assign settled = (settle_cnt >= SW'(SETTLE_TICKS));
    assign run     = en && settled;

    // Settling window: restarts when the enables drop, counts bit ticks.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            settle_cnt <= SW'(SETTLE_TICKS);
        end else begin
            en_q <= en;
            if (en_q && !en)
                settle_cnt <= '0;
            else if (bit_tick && !settled)
                settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign cfg   = '{len8: len8, par: par_mode_e'(par_mode), stop2: stop2};
    assign frame = build_frame(held, cfg);
    assign take  = run && bit_tick && buf_full && (!shift_busy || frame_last);

    uart_tx_dbuf_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .data    (held)
    );

    uart_tx_dbuf_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .tick  (bit_tick),
        .load  (take),
        .frame (frame),
        .busy  (shift_busy),
        .last  (frame_last),
        .txd   (txd)
    );

    always_ff @(posedge clk) begin
        if (rst) tx_irq <= 1'b0;
        else     tx_irq <= run && frame_last;
    end

    AST_HALTED_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!buf_full && !shift_busy && txd)) // R9
        else $error("disabled block not idle");

    AST_HANDOFF_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($fell(buf_full) && $past(run)) |-> shift_busy) // R5
        else $error("buffer emptied without shifter taking the byte");

    AST_IRQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(shift_busy)) // R8
        else $error("interrupt without a frame");

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq) // R8
        else $error("interrupt longer than one clock");

endmodule

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       clk_en = 1'b0, tx_en = 1'b0;
    logic       len8 = 1'b1, stop2 = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, buf_full, shift_busy, tx_irq;

    int checks = 0, fails = 0;
    int irq_cnt = 0;
    logic [1:0] tcnt = 2'd0;
    logic last_tick = 1'b0;
    logic log_bits [0:2047];
    int   log_n = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    uart_tx_dbuf dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .clk_en(clk_en), .tx_en(tx_en),
        .len8(len8), .par_mode(par_mode), .stop2(stop2), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .buf_full(buf_full), .shift_busy(shift_busy), .tx_irq(tx_irq)
    );

    // Bit tick every fourth clock, driven away from the active edge.
    always @(negedge clk) begin
        tcnt     <= tcnt + 2'd1;
        bit_tick <= (tcnt == 2'd2);
    end
    always @(posedge clk) last_tick <= bit_tick;

    // Record the line once per bit time, just after each tick edge.
    always @(negedge clk) begin
        if (last_tick && log_n < 2048) begin
            log_bits[log_n] = txd;
            log_n++;
        end
        if (tx_irq) irq_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Independent model of the line pattern.
    task automatic exp_frame(input logic [7:0] d, output logic [11:0] bits, output int n);
        int nd;
        int ones;
        bits = 12'hFFF;
        n = 0;
        bits[n] = 1'b0; n++;
        nd = len8 ? 8 : 7;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            bits[n] = d[i]; ones += d[i]; n++;
        end
        if (par_mode == 2'b01) begin bits[n] = 1'b0; n++; end
        if (par_mode == 2'b10) begin bits[n] = (ones % 2 == 0); n++; end
        if (par_mode == 2'b11) begin bits[n] = (ones % 2 == 1); n++; end
        n += stop2 ? 2 : 1;
    endtask

    // Find (or, if strict, require) a start bit at 'from' and compare the frame.
    task automatic check_frame(input string req, input logic [7:0] d, input int from,
                               input bit strict, output int next);
        logic [11:0] eb, ab;
        int n, s;
        exp_frame(d, eb, n);
        s = from;
        if (!strict) while (s < log_n && log_bits[s] !== 1'b0) s++;
        ab = 12'hFFF;
        for (int i = 0; i < n; i++) ab[i] = (s + i < log_n) ? log_bits[s + i] : 1'bx;
        chk(req, {20'd0, ab}, {20'd0, eb});
        next = s + n;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_one(input string req, input logic [7:0] d);
        int mark, nx, irq0;
        mark = log_n; irq0 = irq_cnt;
        write_byte(d);
        repeat (70) @(negedge clk);
        check_frame(req, d, mark, 1'b0, nx);
        chk({req, " R8 irq per frame"}, irq_cnt - irq0, 1);
    endtask

    task automatic test_reset();
        chk("R1 txd", txd, 1); chk("R1 buf_full", buf_full, 0);
        chk("R1 shift_busy", shift_busy, 0); chk("R1 tx_irq", tx_irq, 0);
    endtask

    task automatic test_formats();
        len8 = 1; par_mode = 2'b00; stop2 = 0; send_one("R2 8N1 A5", 8'hA5);
        len8 = 0; par_mode = 2'b11; stop2 = 1; send_one("R3 R4 7E2 B5", 8'hB5);
        len8 = 0; par_mode = 2'b11; stop2 = 0; send_one("R4 7E1 01", 8'h01);
        len8 = 1; par_mode = 2'b10; stop2 = 0; send_one("R4 8O1 03", 8'h03);
        len8 = 1; par_mode = 2'b01; stop2 = 1; send_one("R4 8Z2 07", 8'h07);
        len8 = 1; par_mode = 2'b00; stop2 = 0;
    endtask

    task automatic test_back_to_back();
        int mark, irq0, nx, nx2;
        mark = log_n; irq0 = irq_cnt;
        write_byte(8'h3C);
        chk("R5 full after write", buf_full, 1);
        repeat (8) @(negedge clk);
        chk("R5 full cleared at handoff", buf_full, 0);
        chk("R5 shifting after handoff", shift_busy, 1);
        write_byte(8'hC3);
        chk("R5 second byte waits", buf_full, 1);
        write_byte(8'h99);
        repeat (110) @(negedge clk);
        check_frame("R2 first frame", 8'h3C, mark, 1'b0, nx);
        check_frame("R7 R6 second frame adjacent", 8'hC3, nx, 1'b1, nx2);
        chk("R6 no third frame", (nx2 < log_n && log_bits[nx2] === 1'b0) ? 1 : 0, 0);
        chk("R6 idle after two", {shift_busy, buf_full, txd}, 3'b001);
        chk("R8 two irq pulses", irq_cnt - irq0, 2);
    endtask

    task automatic test_disable();
        int irq0, mark, nx;
        irq0 = irq_cnt;
        write_byte(8'h55);
        repeat (12) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 abort idle", {txd, buf_full, shift_busy}, 3'b100);
        write_byte(8'h11);
        chk("R9 write ignored while disabled", buf_full, 0);
        tx_en = 1'b1;
        write_byte(8'h22);
        chk("R10 write ignored while settling", buf_full, 0);
        chk("R9 no irq on abort", irq_cnt - irq0, 0);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        write_byte(8'h33);
        chk("R9 clk_en alone blocks", {buf_full, shift_busy}, 2'b00);
        clk_en = 1'b1;
        repeat (12) @(negedge clk);
        mark = log_n;
        send_one("R10 accepted after settling", 8'h6A);
        check_frame("R10 settled frame", 8'h6A, mark, 1'b0, nx);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        clk_en = 1'b1; tx_en = 1'b1;
        repeat (4) @(negedge clk);
        test_formats();
        test_back_to_back();
        test_disable();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule